// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block copies data from one region of system memory to another. Software does not program it with addresses directly. Instead it builds a chain of descriptors in memory, where each descriptor names a source, a destination, a byte count and the location of the following descriptor. Software then writes the address of the first descriptor into a register and sets a run bit. The engine walks the chain by itself and copies each region one 32-bit word at a time. It stops after a descriptor flagged as the final one.

All traffic uses one word-wide memory master port with a single request held until it is acknowledged. That port carries descriptor reads, source reads and destination writes in turn. A small register window lets software start and stop the engine, poll a busy flag and watch progress. Progress is shown as the descriptor currently being handled and the bytes written so far for it. Each descriptor can ask for a one-cycle interrupt pulse when its data has been written. Each descriptor also carries a scrambler configuration word. The engine does not act on this word: it only decodes it and holds it on output pins for a neighbouring data-path block.

Top module: `dma_chain_copier`

## Requirements
- R1: After reset the engine is idle. All readable registers read 0, and `mem_req`, `irq` and every scrambler output are 0.
- R2: Descriptor fetch reads five words at pointer+0, +4, +8, +12 and +16, in that order. The words are, in order: source address, destination address, control word, next pointer and scrambler word. In the control word, bits [24:0] are the byte count (up to 0x1000000), bit 30 is the interrupt enable and bit 31 marks the final descriptor. The three trailing words of a descriptor are never read.
- R3: For a byte count N (a multiple of 4), the engine alternates a read of source+k with a write of destination+k. It does this for k = 0, 4, … N-4 in ascending order and writes the word it just read. It touches nothing beyond destination+N-4.
- R4: After a descriptor without the final flag, the engine fetches the next descriptor from the address in its next pointer. After a descriptor with the final flag, it makes no further memory access.
- R5: Register word offsets (`reg_addr`): 0 first-descriptor address, 1 control (bit 0 RUN), 2 status (bit 0 busy), 3 current descriptor, 4 current byte. Processing starts only when RUN is 1 while idle. A write to the first-descriptor register while busy is ignored.
- R6: Status busy reads 1 while the chain is processed and 0 once it completes. While RUN stays 1 after completion, nothing restarts, even if 1 is written again. A new run needs RUN to go to 0 and then back to 1.
- R7: When RUN is cleared, the engine returns to idle as soon as any access in flight has been acknowledged. It issues no further requests.
- R8: The current-descriptor register holds the address of the descriptor being (or last) handled. The current-byte register holds the bytes already written for it, always a multiple of 4 and reset to 0 at each fetch.
- R9: When a descriptor with interrupt enable set completes its final destination write, `irq` is high for exactly one cycle, the cycle after that write is acknowledged.
- R10: A descriptor with byte count 0 performs no data access and raises no interrupt. The engine goes straight on to the chain decision.
- R11: Scrambler outputs come from descriptor word 4 as it is fetched: bit 0 enable, bit 1 sequence start, bit 2 sequence end, bits [5:4] mode, bits [13:8] key slot, bit 16 initialise.
- R12: A request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Per-descriptor completion pulse |
| scr_en | output | 1 | Scrambler enable |
| scr_sos | output | 1 | Scrambler sequence start |
| scr_eos | output | 1 | Scrambler sequence end |
| scr_mode | output | 2 | Scrambler mode select |
| scr_key | output | 6 | Scrambler key slot |
| scr_init | output | 1 | Scrambler initialise flag |

## Verification
The hardest situation to reach is a stop that arrives in the middle of a long copy, while a request is waiting for its acknowledge. The engine must finish that one handshake, go idle and then accept a fresh chain. To get there, the bench gives one descriptor a 2 KiB byte count and lets the memory model answer with random latency. It clears RUN after a fixed delay, which lands at an arbitrary point in the read/write alternation. A second hard case is a chain mixing zero-length descriptors with interrupt-enabled ones placed at scattered, non-ascending addresses. Fixed-seed random chains of up to four descriptors cover this, along with a directed chain whose middle descriptor is empty.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  // engine sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_NEXT,
    ST_HOLD
  } dcc_state_e;

  // register window word offsets
  localparam logic [2:0] RA_FIRST = 3'd0;
  localparam logic [2:0] RA_CTRL  = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_CDESC = 3'd3;
  localparam logic [2:0] RA_CBYTE = 3'd4;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int STAT_BUSY_BIT = 0;

  // descriptor word indices that are fetched
  localparam int W_SRC = 0;
  localparam int W_DST = 1;
  localparam int W_CTL = 2;
  localparam int W_NXT = 3;
  localparam int W_SCR = 4;
  localparam int FETCH_WORDS = W_SCR + 1;

  // control word flag positions
  localparam int CTL_IE_BIT   = 30;
  localparam int CTL_LAST_BIT = 31;

  typedef struct packed {
    logic       init;
    logic [5:0] key;
    logic [1:0] mode;
    logic       eos;
    logic       sos;
    logic       en;
  } dcc_scr_t;

  function automatic dcc_scr_t dcc_unpack_scr(input logic [31:0] w);
    dcc_scr_t s;
    s.en   = w[0];
    s.sos  = w[1];
    s.eos  = w[2];
    s.mode = w[5:4];
    s.key  = w[13:8];
    s.init = w[16];
    return s;
  endfunction

endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dcc_regfile.sv
module dcc_regfile
  import dcc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wen,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           busy,
  input  logic [AW-1:0]  cur_desc,
  input  logic [SZW-1:0] cur_byte,
  output logic [AW-1:0]  first_desc,
  output logic           run
);

  logic          ld_first;
  logic          ld_ctrl;
  logic [AW-1:0] first_d;
  logic          run_d;

  always_comb begin
    ld_first = reg_wen && (reg_addr == RA_FIRST) && !busy;
    ld_ctrl  = reg_wen && (reg_addr == RA_CTRL);
    first_d  = reg_wdata[AW-1:0];
    run_d    = reg_wdata[CTRL_RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_desc <= '0;
      run        <= 1'b0;
    end else begin
      if (ld_first) first_desc <= first_d;
      if (ld_ctrl)  run        <= run_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_FIRST: reg_rdata = 32'(first_desc);
      RA_CTRL:  reg_rdata[CTRL_RUN_BIT] = run;
      RA_STAT:  reg_rdata[STAT_BUSY_BIT] = busy;
      RA_CDESC: reg_rdata = 32'(cur_desc);
      RA_CBYTE: reg_rdata = 32'(cur_byte);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dcc_sequencer.sv
module dcc_sequencer
  import dcc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SZW  = 25,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [AW-1:0]   first_desc,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output dcc_state_e      state,
  output logic [AW-1:0]   desc_ptr,
  output logic [IDXW-1:0] widx,
  output logic [AW-1:0]   src_base,
  output logic [AW-1:0]   dst_base,
  output logic [SZW-1:0]  offset,
  output logic [31:0]     data_buf,
  output logic            busy,
  output logic            irq,
  output dcc_scr_t        scr
);

  dcc_state_e     state_q, state_d;
  logic [AW-1:0]  desc_q, desc_d;
  logic [IDXW-1:0] widx_q, widx_d;
  logic [SZW-1:0] ofs_q, ofs_d;
  logic           irq_q, irq_d;
  logic [AW-1:0]  src_q, dst_q, next_q;
  logic [SZW-1:0] size_q;
  logic           ie_q, last_q;
  dcc_scr_t       scr_q;
  logic [31:0]    dbuf_q;

  logic fetch_ack;
  logic ld_src, ld_dst, ld_ctl, ld_nxt, ld_scr, ld_buf;
  logic [SZW-1:0] ofs_inc;
  logic last_beat;

  always_comb begin
    fetch_ack = (state_q == ST_FETCH) && mem_ack;
    ld_src    = fetch_ack && (widx_q == IDXW'(W_SRC));
    ld_dst    = fetch_ack && (widx_q == IDXW'(W_DST));
    ld_ctl    = fetch_ack && (widx_q == IDXW'(W_CTL));
    ld_nxt    = fetch_ack && (widx_q == IDXW'(W_NXT));
    ld_scr    = fetch_ack && (widx_q == IDXW'(W_SCR));
    ld_buf    = (state_q == ST_READ) && mem_ack;
    ofs_inc   = ofs_q + SZW'(4);
    last_beat = (ofs_inc == size_q);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    desc_d  = desc_q;
    widx_d  = widx_q;
    ofs_d   = ofs_q;
    irq_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run) begin
          state_d = ST_FETCH;
          desc_d  = first_desc;
          widx_d  = '0;
          ofs_d   = '0;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (!run) begin
            state_d = ST_IDLE;
          end else if (widx_q == IDXW'(FETCH_WORDS - 1)) begin
            state_d = (size_q == '0) ? ST_NEXT : ST_READ;
          end else begin
            widx_d = widx_q + IDXW'(1);
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          state_d = run ? ST_WRITE : ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          ofs_d = ofs_inc;
          if (last_beat) irq_d = ie_q;
          if (!run) begin
            state_d = ST_IDLE;
          end else begin
            state_d = last_beat ? ST_NEXT : ST_READ;
          end
        end
      end
      ST_NEXT: begin
        if (!run) begin
          state_d = ST_IDLE;
        end else if (last_q) begin
          state_d = ST_HOLD;
        end else begin
          state_d = ST_FETCH;
          desc_d  = next_q;
          widx_d  = '0;
          ofs_d   = '0;
        end
      end
      ST_HOLD: begin
        if (!run) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      widx_q  <= '0;
      ofs_q   <= '0;
      irq_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      next_q  <= '0;
      size_q  <= '0;
      ie_q    <= 1'b0;
      last_q  <= 1'b0;
      scr_q   <= '0;
      dbuf_q  <= '0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      widx_q  <= widx_d;
      ofs_q   <= ofs_d;
      irq_q   <= irq_d;
      if (ld_src) src_q <= mem_rdata[AW-1:0];
      if (ld_dst) dst_q <= mem_rdata[AW-1:0];
      if (ld_ctl) begin
        size_q <= mem_rdata[SZW-1:0];
        ie_q   <= mem_rdata[CTL_IE_BIT];
        last_q <= mem_rdata[CTL_LAST_BIT];
      end
      if (ld_nxt) next_q <= mem_rdata[AW-1:0];
      if (ld_scr) scr_q  <= dcc_unpack_scr(mem_rdata);
      if (ld_buf) dbuf_q <= mem_rdata;
    end
  end

  always_comb begin
    state    = state_q;
    desc_ptr = desc_q;
    widx     = widx_q;
    src_base = src_q;
    dst_base = dst_q;
    offset   = ofs_q;
    data_buf = dbuf_q;
    busy     = (state_q != ST_IDLE) && (state_q != ST_HOLD);
    irq      = irq_q;
    scr      = scr_q;
  end

endmodule

// File: rtl/dcc_addrgen.sv
module dcc_addrgen
  import dcc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SZW  = 25,
  parameter int IDXW = 3
) (
  input  dcc_state_e      state,
  input  logic [AW-1:0]   desc_ptr,
  input  logic [IDXW-1:0] widx,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  input  logic [SZW-1:0]  offset,
  input  logic [31:0]     data_buf,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata
);

  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] ofs_ext;

  always_comb begin
    fetch_addr = desc_ptr + AW'({widx, 2'b00});
    ofs_ext    = AW'(offset);
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = fetch_addr;
    mem_wdata  = data_buf;
    case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
      end
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = src_base + ofs_ext;
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_base + ofs_ext;
      end
      default: begin
        mem_req  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dma_chain_copier.sv
module dma_chain_copier
  import dcc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq,
  output logic          scr_en,
  output logic          scr_sos,
  output logic          scr_eos,
  output logic [1:0]    scr_mode,
  output logic [5:0]    scr_key,
  output logic          scr_init
);

  localparam int IDXW = $clog2(FETCH_WORDS);

  logic            rst_sync_n;
  logic            busy;
  logic            run;
  logic [AW-1:0]   first_desc;
  dcc_state_e      state;
  logic [AW-1:0]   desc_ptr;
  logic [IDXW-1:0] widx;
  logic [AW-1:0]   src_base;
  logic [AW-1:0]   dst_base;
  logic [SZW-1:0]  offset;
  logic [31:0]     data_buf;
  dcc_scr_t        scr;

  dcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dcc_regfile #(.AW(AW), .SZW(SZW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .cur_desc   (desc_ptr),
    .cur_byte   (offset),
    .first_desc (first_desc),
    .run        (run)
  );

  dcc_sequencer #(.AW(AW), .SZW(SZW), .IDXW(IDXW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .first_desc (first_desc),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .state      (state),
    .desc_ptr   (desc_ptr),
    .widx       (widx),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .offset     (offset),
    .data_buf   (data_buf),
    .busy       (busy),
    .irq        (irq),
    .scr        (scr)
  );

  dcc_addrgen #(.AW(AW), .SZW(SZW), .IDXW(IDXW)) u_agen (
    .state      (state),
    .desc_ptr   (desc_ptr),
    .widx       (widx),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .offset     (offset),
    .data_buf   (data_buf),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  always_comb begin
    scr_en   = scr.en;
    scr_sos  = scr.sos;
    scr_eos  = scr.eos;
    scr_mode = scr.mode;
    scr_key  = scr.key;
    scr_init = scr.init;
  end

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          run,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          irq
);

  // R12: a waiting request holds its attributes
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
    else $error("a_r12_req_hold");

  // R9: interrupt is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq)
    else $error("a_r9_single_pulse");

  // R9: interrupt follows an accepted write
  a_r9_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_we && mem_ack))
    else $error("a_r9_after_write");

  // R7: with RUN clear and no access pending, the engine is idle next cycle
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && (!mem_req || mem_ack)) |=> !busy)
    else $error("a_r7_stop_idle");

  // R6: memory traffic only while busy
  a_r6_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy)
    else $error("a_r6_req_busy");

  // R5: work begins only with RUN set
  a_r5_start_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> run)
    else $error("a_r5_start_run");

endmodule

bind dma_chain_copier dcc_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .run       (run),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq       (irq)
);

// File: tb/sim_dma_chain_copier.sv
`timescale 1ns/1ps
module sim_dma_chain_copier;

  localparam int AW = 32;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        irq;
  logic        scr_en, scr_sos, scr_eos, scr_init;
  logic [1:0]  scr_mode;
  logic [5:0]  scr_key;

  always #2 clk = ~clk;  // 250 MHz

  dma_chain_copier #(.AW(AW), .SZW(25)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq),
    .scr_en(scr_en), .scr_sos(scr_sos), .scr_eos(scr_eos),
    .scr_mode(scr_mode), .scr_key(scr_key), .scr_init(scr_init)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:4095];

  // access log written by the memory model
  logic [31:0] log_a [0:LOGN-1];
  bit          log_w [0:LOGN-1];
  int          log_n = 0;
  int          hs_bad = 0;
  int          irq_cnt = 0;
  int          irq_wide = 0;
  bit          irq_prev = 1'b0;

  // expected log
  logic [31:0] exp_a [0:LOGN-1];
  bit          exp_w [0:LOGN-1];
  int          exp_n;
  int          exp_irq;

  // chain description
  int          c_n;
  logic [31:0] c_addr [0:3];
  logic [31:0] c_src  [0:3];
  logic [31:0] c_dst  [0:3];
  int          c_size [0:3];
  bit          c_ie   [0:3];
  logic [31:0] c_scr  [0:3];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: random latency 0..3, one request at a time
  int unsigned lat = 0;
  bit          pend_q = 1'b0;
  logic [31:0] pend_addr;
  bit          pend_we;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
      lat       = 0;
      pend_q    = 1'b0;
    end else begin
      if (pend_q && (!mem_req || mem_addr != pend_addr || mem_we != pend_we)) hs_bad++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = $urandom_range(0, 3);
      end else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[13:2]];
          if (log_n < LOGN) begin
            log_a[log_n] = mem_addr;
            log_w[log_n] = mem_we;
          end
          log_n++;
        end else begin
          lat--;
        end
      end
      pend_q    = mem_req && !mem_ack;
      pend_addr = mem_addr;
      pend_we   = mem_we;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        if (irq_prev) irq_wide++;
      end
      irq_prev = irq;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] exp_scr(input logic [31:0] w);
    return {w[16], w[13:8], w[5:4], w[2], w[1], w[0]};
  endfunction

  function automatic logic [31:0] dst_fill(input int k);
    return 32'hD0D0_0000 + k;
  endfunction

  // write the chain into memory and build the expected access log
  task automatic place_chain();
    int base = $urandom_range(0, 7);
    exp_n = 0;
    exp_irq = 0;
    for (int i = 0; i < c_n; i++) begin
      c_addr[i] = 32'h100 + 32 * ((base + 3 * i) % 8);
      c_src[i]  = 32'h2000 + 32'h100 * i;
      c_dst[i]  = 32'h3000 + 32'h100 * i;
      c_scr[i]  = $urandom;
      for (int k = 0; k < 64; k++) begin
        mem[(c_src[i] >> 2) + k] = $urandom;
        mem[(c_dst[i] >> 2) + k] = dst_fill(k);
      end
    end
    for (int i = 0; i < c_n; i++) begin
      logic [31:0] ctl;
      int wb = c_addr[i] >> 2;
      ctl = 32'(c_size[i]);
      ctl[30] = c_ie[i];
      ctl[31] = (i == c_n - 1);
      mem[wb + 0] = c_src[i];
      mem[wb + 1] = c_dst[i];
      mem[wb + 2] = ctl;
      mem[wb + 3] = (i == c_n - 1) ? 32'h0 : c_addr[i + 1];
      mem[wb + 4] = c_scr[i];
      for (int k = 5; k < 8; k++) mem[wb + k] = $urandom;
      for (int k = 0; k < 5; k++) begin
        exp_a[exp_n] = c_addr[i] + 4 * k; exp_w[exp_n] = 1'b0; exp_n++;
      end
      for (int k = 0; k < c_size[i] / 4; k++) begin
        exp_a[exp_n] = c_src[i] + 4 * k; exp_w[exp_n] = 1'b0; exp_n++;
        exp_a[exp_n] = c_dst[i] + 4 * k; exp_w[exp_n] = 1'b1; exp_n++;
      end
      if (c_ie[i] && c_size[i] > 0) exp_irq++;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int t = 0;
    repeat (2) @(negedge clk);
    do begin
      reg_read(RA_STAT_B, v);
      t++;
    end while (v[0] && t < 20000);
    check(!v[0], "R6", "busy clears after chain", v, 0);
  endtask

  localparam logic [2:0] RA_FIRST_B = 3'd0;
  localparam logic [2:0] RA_CTRL_B  = 3'd1;
  localparam logic [2:0] RA_STAT_B  = 3'd2;
  localparam logic [2:0] RA_CDESC_B = 3'd3;
  localparam logic [2:0] RA_CBYTE_B = 3'd4;

  task automatic run_and_check();
    logic [31:0] v;
    int bad;
    log_n = 0; irq_cnt = 0; irq_wide = 0;
    reg_write(RA_FIRST_B, c_addr[0]);
    reg_write(RA_CTRL_B, 32'h1);
    wait_idle();
    check(log_n == exp_n, "R4", "access count over chain", log_n, exp_n);
    bad = 0;
    for (int k = 0; k < 5; k++)
      if (log_a[k] != c_addr[0] + 4 * k || log_w[k]) bad++;
    check(bad == 0, "R2", "first descriptor fetch order", bad, 0);
    bad = 0;
    for (int k = 0; k < exp_n && k < LOGN; k++)
      if (log_a[k] != exp_a[k] || log_w[k] != exp_w[k]) bad++;
    check(bad == 0, "R3", "access sequence mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < c_n; i++) begin
      for (int k = 0; k < c_size[i] / 4; k++)
        if (mem[(c_dst[i] >> 2) + k] != mem[(c_src[i] >> 2) + k]) bad++;
      if (mem[(c_dst[i] >> 2) + c_size[i] / 4] != dst_fill(c_size[i] / 4)) bad++;
    end
    check(bad == 0, "R3", "destination data and guard", bad, 0);
    check(irq_cnt == exp_irq, "R9", "interrupt pulses", irq_cnt, exp_irq);
    check(irq_wide == 0, "R9", "interrupt wider than one cycle", irq_wide, 0);
    reg_read(RA_CDESC_B, v);
    check(v == c_addr[c_n - 1], "R8", "current descriptor", v, c_addr[c_n - 1]);
    reg_read(RA_CBYTE_B, v);
    check(v == 32'(c_size[c_n - 1]), "R8", "current byte", v, 32'(c_size[c_n - 1]));
    check({scr_init, scr_key, scr_mode, scr_eos, scr_sos, scr_en} == exp_scr(c_scr[c_n - 1]),
          "R11", "scrambler outputs",
          32'({scr_init, scr_key, scr_mode, scr_eos, scr_sos, scr_en}),
          32'(exp_scr(c_scr[c_n - 1])));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), v);
      check(v == 0, "R1", "register after reset", v, 0);
    end
    check(!mem_req && !irq, "R1", "mem_req/irq after reset", {mem_req, irq}, 0);
    check({scr_init, scr_key, scr_mode, scr_eos, scr_sos, scr_en} == '0, "R1",
          "scrambler outputs after reset",
          32'({scr_init, scr_key, scr_mode, scr_eos, scr_sos, scr_en}), 0);

    // R5: loading the pointer alone does nothing
    c_n = 1; c_size[0] = 16; c_ie[0] = 1'b1;
    place_chain();
    c_scr[0] = 32'h0001_2F37;
    mem[(c_addr[0] >> 2) + 4] = c_scr[0];
    log_n = 0;
    reg_write(RA_FIRST_B, c_addr[0]);
    repeat (20) @(negedge clk);
    check(log_n == 0, "R5", "no access without RUN", log_n, 0);
    reg_read(RA_FIRST_B, v);
    check(v == c_addr[0], "R5", "first pointer loaded while idle", v, c_addr[0]);

    // directed single descriptor with interrupt
    run_and_check();

    // R6: held RUN does not restart, nor does rewriting 1
    n0 = log_n;
    repeat (30) @(negedge clk);
    reg_write(RA_CTRL_B, 32'h1);
    repeat (30) @(negedge clk);
    check(log_n == n0, "R6", "no restart while RUN held", log_n, n0);
    reg_read(RA_STAT_B, v);
    check(v[0] == 1'b0, "R6", "busy stays low after completion", v, 0);
    reg_write(RA_CTRL_B, 32'h0);

    // R10: chain with an empty middle descriptor
    c_n = 3;
    c_size[0] = 8;  c_ie[0] = 1'b0;
    c_size[1] = 0;  c_ie[1] = 1'b1;
    c_size[2] = 12; c_ie[2] = 1'b1;
    place_chain();
    run_and_check();
    check(irq_cnt == 1, "R10", "empty descriptor raises no interrupt", irq_cnt, 1);
    check(exp_n == 5 + 4 + 5 + 5 + 6, "R10", "empty descriptor has no data access", exp_n, 25);
    reg_write(RA_CTRL_B, 32'h0);

    // random chains
    for (int it = 0; it < 6; it++) begin
      c_n = $urandom_range(1, 4);
      for (int i = 0; i < c_n; i++) begin
        c_size[i] = 4 * $urandom_range(0, 40);
        c_ie[i]   = 1'($urandom_range(0, 1));
      end
      place_chain();
      run_and_check();
      reg_write(RA_CTRL_B, 32'h0);
    end

    // R7: stop in the middle of a long copy
    c_n = 1; c_size[0] = 32'h800; c_ie[0] = 1'b1;
    place_chain();
    log_n = 0;
    reg_write(RA_FIRST_B, c_addr[0]);
    reg_write(RA_CTRL_B, 32'h1);
    repeat (150) @(negedge clk);
    reg_read(RA_CBYTE_B, v);
    check(v > 0 && v < 32'h800 && v[1:0] == 2'b00, "R8", "mid-copy byte progress", v, 32'h400);
    reg_write(RA_FIRST_B, 32'h1E0);
    reg_read(RA_FIRST_B, v);
    check(v == c_addr[0], "R5", "pointer write ignored while busy", v, c_addr[0]);
    reg_write(RA_CTRL_B, 32'h0);
    repeat (6) @(negedge clk);
    reg_read(RA_STAT_B, v);
    check(v[0] == 1'b0, "R7", "idle after RUN cleared", v, 0);
    check(mem_req == 1'b0, "R7", "no request after stop", 32'(mem_req), 0);
    n0 = log_n;
    repeat (20) @(negedge clk);
    check(log_n == n0, "R7", "no accesses after stop", log_n, n0);
    reg_write(RA_FIRST_B, 32'h1E0);
    reg_read(RA_FIRST_B, v);
    check(v == 32'h1E0, "R5", "pointer accepted after stop", v, 32'h1E0);

    // R6: fresh run after RUN 0 -> 1
    c_n = 2;
    c_size[0] = 20; c_ie[0] = 1'b1;
    c_size[1] = 32; c_ie[1] = 1'b0;
    place_chain();
    run_and_check();
    reg_write(RA_CTRL_B, 32'h0);

    check(hs_bad == 0, "R12", "request changed before acknowledge", hs_bad, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule